// File: doc/BRIEF.md
# Indirect Configuration Register Port for a Gate Pipeline

This block lets a host program and inspect a pipelined gate fabric through one 32-bit input word, one 32-bit output word, a write strobe and a read strobe. Behind that narrow port sit 256 addressable locations. The low sixteen hold the starting amplitude words of the sixteen lanes. The upper half (128 to 255) holds the route-select bytes that drive the fabric's stage multiplexers. Addresses 16 to 127 are unused.

A register is programmed by two write strobes in a row. The first strobe names the target address and the second strobe carries the value. A one-bit phase flag alternates between these two roles. To read, the host strobes an address with the read strobe also high. The output word then shows the selected location. For addresses 0 to 15 this is the matching lane of the fabric's final stage, not the starting value.

The block also holds a free-running 16-bit pseudo-random generator. The fabric's controlled gates compare its value against a control lane's probability.

Top module: `gate_cfg_port`

## Requirements
- R1: While rst_n is low and after its release, the phase is address, all lane words and select bytes read zero, the read pointer is 0, and the generator holds 0xACE1.
- R2: A strobe with wr_en=1 and rd_en=0 in the address phase latches wr_data[7:0] as the target address and changes no stored value.
- R3: The next such strobe (data phase) writes wr_data into the target and returns the phase to address. Targets 0 to 15 store all 32 bits into lane word n, which appears on init_flat[32n+31:32n].
- R4: A data-phase write to target 128+k stores wr_data[7:0] into select byte k, which appears on sel_flat[8k+7:8k].
- R5: A data-phase write to a target from 16 to 127 changes no stored value, and the phase still returns to address.
- R6: A strobe with wr_en=1 and rd_en=1 loads wr_data[7:0] into the read pointer. It leaves the phase and all stored values unchanged.
- R7: From the cycle after the read pointer loads, rd_data shows the selected location. Pointer n in 0 to 15 gives result_flat[32n+31:32n], and rd_data follows that input as it changes. Pointer 128+k gives select byte k zero-extended. Pointers 16 to 127 give zero.
- R8: rd_en high with wr_en low, and any wr_data with wr_en low, change neither the phase, the read pointer nor any stored value.
- R9: Every cycle out of reset the generator shifts right by one. If the bit shifted out was 1, the result is XORed with 0xB400. The generator never holds zero.
- R10: Bits 31:8 of wr_data are ignored when it carries an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, qualifies wr_en as a read-pointer load |
| wr_data | input | 32 | Address or data word from the host |
| rd_data | output | 32 | Value at the read pointer |
| result_flat | input | 512 | Final-stage lane words from the fabric, lane n at bits 32n+31:32n |
| init_flat | output | 512 | Starting lane words to the fabric |
| sel_flat | output | 1024 | Route-select bytes to the fabric, byte k at bits 8k+7:8k |
| lfsr_out | output | 16 | Pseudo-random value for controlled gates |

## Verification
The bench targets phase slips. A design that toggles the phase on a read-pointer load, or on a lone read strobe, would treat the next data word as an address, so the select byte written afterwards lands in the wrong place. Writes to the unused range are checked at the outputs: a design that aliased addresses 16 to 127 onto the lane words would overwrite lane words. It would also fail to return zero on readback. The bench checks readback of lanes 0 to 15 against the live final-stage input, after changing that input, to catch a design that returns the stored starting word instead. Address words with high bits set, and a long stretch of generator steps, catch truncation and tap errors.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/gcp_lfsr.sv
module gcp_lfsr #(
    parameter int unsigned           WIDTH = 16,
    parameter logic [WIDTH-1:0]      TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0]      SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);

    typedef struct packed {
        logic [WIDTH-1:0] state;
    } lfsr_s;

    lfsr_s r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.state = r_q.state >> 1;
        if (r_q.state[0]) begin
            r_d.state = r_d.state ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign value = r_q.state;

    // R9
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state != '0);

    // R9
    lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (r_q.state != $past(r_q.state)));

endmodule

// File: rtl/gcp_ctrl.sv
module gcp_ctrl
    import gcp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              bank_we,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [ADDR_W-1:0] rd_addr
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] wr_addr;
        logic [ADDR_W-1:0] rd_addr;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  host_wr;
    logic  ptr_load;

    assign host_wr  = wr_en && !rd_en;
    assign ptr_load = wr_en && rd_en;

    always_comb begin
        r_d = r_q;
        if (ptr_load) begin
            r_d.rd_addr = addr_in;
        end else if (host_wr) begin
            if (r_q.phase == PH_ADDR) begin
                r_d.wr_addr = addr_in;
                r_d.phase   = PH_DATA;
            end else begin
                r_d.phase   = PH_ADDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase   <= PH_ADDR;
            r_q.wr_addr <= '0;
            r_q.rd_addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bank_we   = host_wr && (r_q.phase == PH_DATA);
    assign bank_addr = r_q.wr_addr;
    assign rd_addr   = r_q.rd_addr;

    // R2
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && r_q.phase == PH_ADDR) |=> (r_q.wr_addr == $past(addr_in)));

    // R3
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (r_q.phase != $past(r_q.phase)));

    // R6
    ptr_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ($stable(r_q.phase) && $stable(r_q.wr_addr)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(r_q.phase) && $stable(r_q.rd_addr)));

endmodule

// File: rtl/gcp_bank.sv
module gcp_bank #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_QUBIT = 16,
    parameter int unsigned SEL_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [ADDR_W-1:0]           raddr,
    input  logic [N_QUBIT*DATA_W-1:0]   result_flat,
    output logic [DATA_W-1:0]           rdata,
    output logic [N_QUBIT*DATA_W-1:0]   init_flat,
    output logic [(2**(ADDR_W-1))*SEL_W-1:0] sel_flat
);

    localparam int unsigned N_SEL     = 2 ** (ADDR_W - 1);
    localparam int unsigned SEL_IDX_W = ADDR_W - 1;
    localparam int unsigned Q_IDX_W   = $clog2(N_QUBIT);
    localparam logic [ADDR_W-1:0] Q_LIMIT = ADDR_W'(N_QUBIT);

    typedef struct packed {
        logic [N_QUBIT-1:0][DATA_W-1:0] qinit;
        logic [N_SEL-1:0][SEL_W-1:0]    sel;
    } bank_s;

    bank_s r_d, r_q;
    logic [N_QUBIT-1:0][DATA_W-1:0] res_w;
    logic w_sel, w_q, w_none;

    assign res_w  = result_flat;
    assign w_sel  = we && waddr[ADDR_W-1];
    assign w_q    = we && !waddr[ADDR_W-1] && (waddr < Q_LIMIT);
    assign w_none = we && !waddr[ADDR_W-1] && (waddr >= Q_LIMIT);

    always_comb begin
        r_d = r_q;
        if (w_sel) begin
            r_d.sel[waddr[SEL_IDX_W-1:0]] = wdata[SEL_W-1:0];
        end else if (w_q) begin
            r_d.qinit[waddr[Q_IDX_W-1:0]] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr[ADDR_W-1]) begin
            rdata[SEL_W-1:0] = r_q.sel[raddr[SEL_IDX_W-1:0]];
        end else if (raddr < Q_LIMIT) begin
            rdata = res_w[raddr[Q_IDX_W-1:0]];
        end
    end

    assign init_flat = r_q.qinit;
    assign sel_flat  = r_q.sel;

    // R3
    qinit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q |=> (r_q.qinit[$past(waddr[Q_IDX_W-1:0])] == $past(wdata)));

    // R4
    sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_sel |=> (r_q.sel[$past(waddr[SEL_IDX_W-1:0])] == $past(wdata[SEL_W-1:0])));

    // R5
    hole_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_none |=> $stable(r_q));

    // R8
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(r_q));

endmodule

// File: rtl/gate_cfg_port.sv
module gate_cfg_port #(
    parameter int unsigned          ADDR_W     = 8,
    parameter int unsigned          DATA_W     = 32,
    parameter int unsigned          N_QUBIT    = 16,
    parameter int unsigned          SEL_W      = 8,
    parameter int unsigned          LFSR_W     = 16,
    parameter logic [LFSR_W-1:0]    LFSR_TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0]    LFSR_SEED  = 16'hACE1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic                                  rd_en,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [DATA_W-1:0]                     rd_data,
    input  logic [N_QUBIT*DATA_W-1:0]             result_flat,
    output logic [N_QUBIT*DATA_W-1:0]             init_flat,
    output logic [(2**(ADDR_W-1))*SEL_W-1:0]      sel_flat,
    output logic [LFSR_W-1:0]                     lfsr_out
);

    logic              bank_we;
    logic [ADDR_W-1:0] bank_addr;
    logic [ADDR_W-1:0] rd_addr;

    gcp_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr_in   (wr_data[ADDR_W-1:0]),
        .bank_we   (bank_we),
        .bank_addr (bank_addr),
        .rd_addr   (rd_addr)
    );

    gcp_bank #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .N_QUBIT (N_QUBIT),
        .SEL_W   (SEL_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (bank_we),
        .waddr       (bank_addr),
        .wdata       (wr_data),
        .raddr       (rd_addr),
        .result_flat (result_flat),
        .rdata       (rd_data),
        .init_flat   (init_flat),
        .sel_flat    (sel_flat)
    );

    gcp_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (lfsr_out)
    );

    // R1
    reset_seed_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (lfsr_out == LFSR_SEED));

endmodule

// File: tb/gate_cfg_port_test.sv
module gate_cfg_port_test;

    localparam int NQ = 16;
    localparam int NS = 128;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [511:0]  result_flat;
    logic [511:0]  init_flat;
    logic [1023:0] sel_flat;
    logic [15:0]   lfsr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_init [NQ];
    logic [7:0]  m_sel  [NS];
    logic [31:0] m_res  [NQ];

    // {address word, data word}
    localparam logic [63:0] VEC [NV] = '{
        {32'h0000_0000, 32'hDEAD_BEEF},
        {32'h0000_000F, 32'h1234_5678},
        {32'h0000_0080, 32'h0000_00A5},
        {32'h0000_00FF, 32'hFFFF_FF3C},
        {32'h0000_0010, 32'hCAFE_F00D},
        {32'h0000_007F, 32'h1111_1111},
        {32'hFFFF_FF03, 32'h8000_0001},
        {32'h0000_0080, 32'h0000_005A},
        {32'hABCD_EF9C, 32'h7777_77C3},
        {32'h0000_0005, 32'h0F0F_0F0F}
    };

    gate_cfg_port uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .result_flat (result_flat),
        .init_flat   (init_flat),
        .sel_flat    (sel_flat),
        .lfsr_out    (lfsr_out)
    );

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NQ; i++) result_flat[i*32 +: 32] = m_res[i];
    end

    task automatic chk(string req, logic [1023:0] act, logic [1023:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] exp_init();
        logic [511:0] v;
        for (int i = 0; i < NQ; i++) v[i*32 +: 32] = m_init[i];
        return v;
    endfunction

    function automatic logic [1023:0] exp_sel();
        logic [1023:0] v;
        for (int i = 0; i < NS; i++) v[i*8 +: 8] = m_sel[i];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a[7]) return {24'h0, m_sel[a[6:0]]};
        if (a < 8'd16) return m_res[a[3:0]];
        return 32'h0;
    endfunction

    function automatic logic [15:0] prng_next(logic [15:0] s);
        logic [15:0] n;
        n = {1'b0, s[15:1]};
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    task automatic strobe(logic [31:0] d, logic rd);
        @(negedge clk);
        wr_en = 1'b1; rd_en = rd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_data = 32'h5555_AAAA;
    endtask

    task automatic chk_store(string req);
        chk({req, " lanes"}, {512'h0, init_flat}, {512'h0, exp_init()});
        chk({req, " selects"}, sel_flat, exp_sel());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pr;
        logic [7:0]  a;
        for (int i = 0; i < NQ; i++) begin
            m_init[i] = '0;
            m_res[i]  = 32'hA000_0000 | (i * 32'h0001_0111);
        end
        for (int i = 0; i < NS; i++) m_sel[i] = '0;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 lfsr seed", {1008'h0, lfsr_out}, {1008'h0, 16'hACE1});
        chk_store("R1 reset");
        chk("R1 read pointer 0", {992'h0, rd_data}, {992'h0, m_res[0]});
        rst_n = 1'b1;

        // R9: generator sequence
        pr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            pr = prng_next(pr);
            chk("R9 lfsr step", {1008'h0, lfsr_out}, {1008'h0, pr});
        end
        chk("R9 lfsr nonzero", {1023'h0, lfsr_out != 16'h0}, {1023'h0, 1'b1});

        // Table walk: R2 R3 R4 R5 R7 R10
        for (int v = 0; v < NV; v++) begin
            a = VEC[v][39:32];
            strobe(VEC[v][63:32], 1'b0);
            chk_store("R2 address phase no change");
            strobe(VEC[v][31:0], 1'b0);
            if (a[7]) m_sel[a[6:0]] = VEC[v][7:0];
            else if (a < 8'd16) m_init[a[3:0]] = VEC[v][31:0];
            chk_store("R3 R4 R5 R10 data phase");
            strobe(VEC[v][63:32], 1'b1);
            chk("R7 readback", {992'h0, rd_data}, {992'h0, exp_read(a)});
        end

        // R7: lane readback follows live final-stage input
        strobe(32'h0000_0005, 1'b1);
        m_res[5] = 32'h3C3C_1234;
        @(negedge clk);
        chk("R7 live lane", {992'h0, rd_data}, {992'h0, 32'h3C3C_1234});
        // R7: unused range reads zero
        strobe(32'h0000_0040, 1'b1);
        chk("R7 hole reads zero", {992'h0, rd_data}, {992'h0, 32'h0});

        // R6: pointer load between address and data keeps phase
        strobe(32'h0000_0081, 1'b0);
        strobe(32'h0000_0082, 1'b1);
        chk_store("R6 pointer load no store");
        strobe(32'h0000_0077, 1'b0);
        m_sel[1] = 8'h77;
        chk_store("R6 data after pointer load");
        chk("R6 pointer loaded", {992'h0, rd_data}, {992'h0, 32'h0});

        // R8: lone read strobe and idle data have no effect
        strobe(32'h0000_0083, 1'b0);
        @(negedge clk);
        rd_en = 1'b1; wr_data = 32'h0000_0001;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        chk("R8 pointer unchanged", {992'h0, rd_data}, {992'h0, 32'h0});
        chk_store("R8 no store");
        strobe(32'h0000_0099, 1'b0);
        m_sel[3] = 8'h99;
        chk_store("R8 phase intact");

        // R5: unused target keeps phase cycle
        strobe(32'h0000_0020, 1'b0);
        strobe(32'hFFFF_FFFF, 1'b0);
        strobe(32'h0000_0002, 1'b0);
        strobe(32'h2222_2222, 1'b0);
        m_init[2] = 32'h2222_2222;
        chk_store("R5 phase returns");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule